// File: doc/BRIEF.md
# Status Register and Write-Permission Unit for a Serial Memory

This unit sits beside the command decoder of a serial memory. It keeps the eight-bit status byte and decides, one access at a time, whether a pending array write or status write may start its internal cycle. The decoder reports what it has seen on the bus as single-cycle strobes: latch set and latch clear commands, a captured status data byte, a captured array target address, the end of a selection (chip select returning high), the end of a read, and the end of an internal write cycle. The unit answers with a one-cycle grant for each committed write. It also drives the current status byte and the identification-page select.

The grant combines four checks. The write-enable latch must be set. The hardware lock (enable bit together with a low protect pin) freezes the status byte. The block-protect field fences off the upper quarter, the upper half or all of the array. The identification page has its own interlock between its select and lock bits. Bits that model nonvolatile cells (hardware-lock enable, page lock, block-protect field) are plain registers without reset, so they survive the soft reset. The volatile bits are cleared by it.

Top module: `spi_status_guard`

## Requirements
- R1: Status byte layout is bit 7 hardware-lock enable, bit 6 page select, bit 5 constant 0, bit 4 page lock, bits 3:2 block-protect field, bit 1 write-enable latch, bit 0 busy. Synchronous reset clears the latch, busy and page select and leaves bits 7, 4, 3 and 2 unchanged.
- R2: A latch-set strobe sets bit 1 and a latch-clear strobe clears it, with clear winning over set. The end of an internal write cycle also clears bit 1.
- R3: A committed status write changes only bits 7, 6, 4, 3 and 2. Bit 5 always reads 0. The page lock, once 1, cannot be written back to 0.
- R4: A status write whose data has both bit 6 and bit 4 at 1 leaves the page select and page lock unchanged, while bits 7 and 3:2 are still written.
- R5: No array or status write is granted while the write-enable latch is 0.
- R6: With bit 7 at 1 and the protect pin low, status writes are refused. With bit 7 at 0 the pin has no effect.
- R7: If the protect pin goes low with bit 7 at 1 after a status data byte is captured but before the selection ends, that status write is cancelled even if the pin is high again at the end of the selection.
- R8: Field 00 protects nothing, 01 protects addresses 0x3000 to 0x3FFF, 10 protects 0x2000 to 0x3FFF and 11 protects every address. A write to a protected address is refused.
- R9: With the page select at 1, an array write targets the page using address bits 5:0 only. It is refused when the page lock is 1 or the block-protect field is 11.
- R10: The page select returns to 0 at the end of any selection that carried an array write address (granted or not) and on a read-end strobe.
- R11: A granted write sets busy in the same cycle as its grant, and the write-done strobe clears it. While busy is 1, latch strobes, captured bytes and selection ends are ignored.
- R12: Each grant is a one-cycle pulse in the cycle after the selection end, and the two grants are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high soft reset |
| set_wel | input | 1 | Latch-set command strobe |
| clr_wel | input | 1 | Latch-clear command strobe |
| sr_load | input | 1 | Status data byte captured |
| sr_data | input | 8 | Captured status data byte |
| arr_load | input | 1 | Array write target address captured |
| arr_addr | input | ADDR_W | Array write target address |
| cs_rise | input | 1 | Selection ended (chip select high) |
| wr_done | input | 1 | Internal write cycle finished |
| rd_done | input | 1 | Read access finished |
| wp_n | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Current status byte |
| arr_grant | output | 1 | Array write may start its cycle |
| sr_grant | output | 1 | Status write may start its cycle |
| id_sel | output | 1 | Identification page selected |

## Verification
The bench builds the unit with its default ADDR_W of 14 and ID_W of 6. This puts the quarter and half fence posts at 0x3000 and 0x2000, so the bench reaches the exact boundary addresses on both sides. With a 6-bit page offset, a high main-array address such as 0x3FC5 folds to page offset 5. That separates a page write that only looks protected from one that really is. The directed part walks the page select and lock interlock, the pin cancellation window and persistence across the soft reset.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int unsigned SR_W   = 8;
  localparam int unsigned B_HWEN = 7;
  localparam int unsigned B_IPS  = 6;
  localparam int unsigned B_LOCK = 4;
  localparam int unsigned B_BPH  = 3;
  localparam int unsigned B_BPL  = 2;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_e;

  typedef struct packed {
    logic       hw_lock_en;
    logic       id_sel;
    logic       zero5;
    logic       id_lock;
    logic [1:0] bp;
    logic       wel;
    logic       busy;
  } status_t;
endpackage

// File: rtl/sg_range_check.sv
module sg_range_check
  import sg_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  logic [1:0]    bp,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW:0] SPAN      = (AW+1)'(1) << AW;
  localparam logic [AW:0] QTR_BASE  = SPAN - (SPAN >> 2);
  localparam logic [AW:0] HALF_BASE = SPAN >> 1;

  logic [AW:0] wide;
  assign wide = {1'b0, addr};

  always_comb begin
    case (bp)
      BP_NONE:    hit = 1'b0;
      BP_QUARTER: hit = (wide >= QTR_BASE);
      BP_HALF:    hit = (wide >= HALF_BASE);
      default:    hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/sg_status_file.sv
module sg_status_file
  import sg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            set_wel,
  input  logic            clr_wel,
  input  logic            sr_fire,
  input  logic [SR_W-1:0] sr_val,
  input  logic            arr_fire,
  input  logic            id_end,
  input  logic            rd_done,
  input  logic            wr_done,
  output status_t         st
);
  // persistent cells: no reset, power-up value only
  logic       hw_en = 1'b0;
  logic       lock  = 1'b0;
  logic [1:0] bp    = 2'b00;
  logic       wel, busy, ips;
  logic       both;
  logic       unused_val;

  assign both       = sr_val[B_IPS] & sr_val[B_LOCK];
  assign unused_val = ^{sr_val[5], sr_val[1:0]};

  always_ff @(posedge clk) begin
    if (sr_fire) begin
      hw_en <= sr_val[B_HWEN];
      bp    <= sr_val[B_BPH:B_BPL];
      if (!both) lock <= lock | sr_val[B_LOCK];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel  <= 1'b0;
      busy <= 1'b0;
      ips  <= 1'b0;
    end else begin
      if (wr_done && busy)        wel <= 1'b0;
      else if (!busy && clr_wel)  wel <= 1'b0;
      else if (!busy && set_wel)  wel <= 1'b1;

      if (sr_fire || arr_fire)    busy <= 1'b1;
      else if (wr_done)           busy <= 1'b0;

      if (sr_fire && !both)       ips <= sr_val[B_IPS];
      else if (id_end || rd_done) ips <= 1'b0;
    end
  end

  assign st = '{hw_lock_en: hw_en, id_sel: ips, zero5: 1'b0, id_lock: lock,
                bp: bp, wel: wel, busy: busy};
endmodule

// File: rtl/sg_commit_ctrl.sv
module sg_commit_ctrl
  import sg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  logic            wel,
  input  logic            sr_load,
  input  logic [SR_W-1:0] sr_data,
  input  logic            sr_ok,
  input  logic            arr_load,
  input  logic            arr_ok,
  input  logic            cs_rise,
  output logic            sr_fire,
  output logic            arr_fire,
  output logic            id_end,
  output logic [SR_W-1:0] sr_buf,
  output logic            sr_grant,
  output logic            arr_grant
);
  logic sr_pend, arr_pend, arr_seen, commit;

  assign commit   = cs_rise && !busy && !rst;
  assign sr_fire  = commit && sr_pend && sr_ok;
  assign arr_fire = commit && !sr_pend && arr_pend && wel;
  assign id_end   = commit && arr_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_pend   <= 1'b0;
      arr_pend  <= 1'b0;
      arr_seen  <= 1'b0;
      sr_buf    <= '0;
      sr_grant  <= 1'b0;
      arr_grant <= 1'b0;
    end else begin
      sr_grant  <= sr_fire;
      arr_grant <= arr_fire;
      if (commit) begin
        sr_pend  <= 1'b0;
        arr_pend <= 1'b0;
        arr_seen <= 1'b0;
      end else if (!busy) begin
        if (sr_load) begin
          sr_pend <= sr_ok;
          sr_buf  <= sr_data;
        end else if (!sr_ok) begin
          sr_pend <= 1'b0;  // pin dropped or latch cleared mid-selection
        end
        if (arr_load) begin
          arr_pend <= arr_ok;
          arr_seen <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
  import sg_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned ID_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_wel,
  input  logic              clr_wel,
  input  logic              sr_load,
  input  logic [SR_W-1:0]   sr_data,
  input  logic              arr_load,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              cs_rise,
  input  logic              wr_done,
  input  logic              rd_done,
  input  logic              wp_n,
  output logic [SR_W-1:0]   status_o,
  output logic              arr_grant,
  output logic              sr_grant,
  output logic              id_sel
);
  localparam int unsigned ID_PAD = ADDR_W - ID_W;

  status_t           st;
  logic [ADDR_W-1:0] tgt;
  logic              hit, arr_ok, sr_ok;
  logic              sr_fire, arr_fire, id_end;
  logic [SR_W-1:0]   sr_buf;

  assign tgt    = st.id_sel ? {{ID_PAD{1'b0}}, arr_addr[ID_W-1:0]} : arr_addr;
  assign arr_ok = st.wel && !hit &&
                  !(st.id_sel && (st.id_lock || st.bp == BP_ALL));
  assign sr_ok  = st.wel && !(st.hw_lock_en && !wp_n);

  sg_range_check #(.AW(ADDR_W)) u_rng (
    .bp   (st.bp),
    .addr (tgt),
    .hit  (hit)
  );

  sg_commit_ctrl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .busy      (st.busy),
    .wel       (st.wel),
    .sr_load   (sr_load),
    .sr_data   (sr_data),
    .sr_ok     (sr_ok),
    .arr_load  (arr_load),
    .arr_ok    (arr_ok),
    .cs_rise   (cs_rise),
    .sr_fire   (sr_fire),
    .arr_fire  (arr_fire),
    .id_end    (id_end),
    .sr_buf    (sr_buf),
    .sr_grant  (sr_grant),
    .arr_grant (arr_grant)
  );

  sg_status_file u_sf (
    .clk      (clk),
    .rst      (rst),
    .set_wel  (set_wel),
    .clr_wel  (clr_wel),
    .sr_fire  (sr_fire),
    .sr_val   (sr_buf),
    .arr_fire (arr_fire),
    .id_end   (id_end),
    .rd_done  (rd_done),
    .wr_done  (wr_done),
    .st       (st)
  );

  assign status_o = st;
  assign id_sel   = st.id_sel;
endmodule

// File: rtl/sg_checker.sv
module sg_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] status_o,
  input logic       arr_grant,
  input logic       sr_grant,
  input logic       wp_n
);
  p_bit5_zero_r3: assert property (@(posedge clk) disable iff (rst)
    status_o[5] == 1'b0);
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    $past(status_o[4]) |-> status_o[4]);
  p_arr_needs_wel_r5: assert property (@(posedge clk) disable iff (rst)
    arr_grant |-> $past(status_o[1]));
  p_sr_needs_wel_r5: assert property (@(posedge clk) disable iff (rst)
    sr_grant |-> $past(status_o[1]));
  p_pin_lock_r6: assert property (@(posedge clk) disable iff (rst)
    sr_grant |-> $past(!(status_o[7] && !wp_n)));
  p_page_sel_clear_r10: assert property (@(posedge clk) disable iff (rst)
    arr_grant |-> !status_o[6]);
  p_busy_on_grant_r11: assert property (@(posedge clk) disable iff (rst)
    (arr_grant || sr_grant) |-> status_o[0]);
  p_wel_frozen_busy_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(status_o[0]) && status_o[0]) |-> $stable(status_o[1]));
  p_grant_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arr_grant, sr_grant}));
  p_grant_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    arr_grant |=> !arr_grant);
endmodule

bind spi_status_guard sg_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .status_o  (status_o),
  .arr_grant (arr_grant),
  .sr_grant  (sr_grant),
  .wp_n      (wp_n)
);

// File: tb/spi_status_guard_tb.sv
module spi_status_guard_tb;
  localparam int unsigned AW = 14;
  localparam logic [6:0] S_SET = 7'd1,  S_CLR = 7'd2,  S_SRL = 7'd4,
                         S_ARL = 7'd8,  S_CSR = 7'd16, S_WRD = 7'd32,
                         S_RDD = 7'd64;

  typedef struct packed {
    logic [1:0]    bp;
    logic          wel;
    logic [AW-1:0] addr;
    logic          exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b1, 14'h3FFF, 1'b1},
    '{2'b00, 1'b0, 14'h0000, 1'b0},
    '{2'b01, 1'b1, 14'h2FFF, 1'b1},
    '{2'b01, 1'b1, 14'h3000, 1'b0},
    '{2'b10, 1'b1, 14'h1FFF, 1'b1},
    '{2'b10, 1'b1, 14'h2000, 1'b0},
    '{2'b11, 1'b1, 14'h0000, 1'b0},
    '{2'b01, 1'b1, 14'h3FFF, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] strb = '0;
  logic [7:0] sr_d = '0;
  logic [AW-1:0] addr = '0;
  logic wp_n = 1'b1;
  logic [7:0] status_o;
  logic arr_grant, sr_grant, id_sel;
  logic g_arr, g_sr;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_status_guard #(.ADDR_W(AW), .ID_W(6)) u_dut (
    .clk(clk), .rst(rst), .set_wel(strb[0]), .clr_wel(strb[1]),
    .sr_load(strb[2]), .sr_data(sr_d), .arr_load(strb[3]), .arr_addr(addr),
    .cs_rise(strb[4]), .wr_done(strb[5]), .rd_done(strb[6]), .wp_n(wp_n),
    .status_o(status_o), .arr_grant(arr_grant), .sr_grant(sr_grant),
    .id_sel(id_sel)
  );

  task automatic cyc(input logic [6:0] s);
    @(negedge clk);
    strb = s;
    @(posedge clk);
    #1;
    g_arr = arr_grant;
    g_sr  = sr_grant;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_status(input logic [7:0] d);
    cyc(S_SET);
    sr_d = d;
    cyc(S_SRL);
    cyc(S_CSR);
    if (g_sr) cyc(S_WRD);
    cyc('0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 reset status", status_o, 8'h00);
    chk("R12 reset grants", {6'b0, arr_grant, sr_grant}, 8'h00);
    chk("R1 reset id_sel", {7'b0, id_sel}, 8'h00);
    // R2 latch set / clear
    cyc(S_SET);            chk("R2 set latch", status_o, 8'h02);
    cyc(S_SET | S_CLR);    chk("R2 clear wins", status_o, 8'h00);

    // R8 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      wr_status({4'b0000, VECS[i].bp, 2'b00});
      if (VECS[i].wel) cyc(S_SET);
      addr = VECS[i].addr;
      cyc(S_ARL);
      cyc(S_CSR);
      chk($sformatf("R8 R5 vector %0d grant", i), {7'b0, g_arr}, {7'b0, VECS[i].exp});
      if (g_arr) begin
        cyc(S_WRD);
        chk($sformatf("R2 latch cleared after cycle %0d", i), status_o,
            {4'b0000, VECS[i].bp, 2'b00});
      end
    end
    // status now bp=01, latch 1
    cyc(S_CLR);              chk("R2 clear", status_o, 8'h04);

    // R3 R4 R11 R12
    cyc(S_SET);
    sr_d = 8'hFF; cyc(S_SRL);
    cyc(S_CSR);              chk("R12 status grant", {7'b0, g_sr}, 8'h01);
    chk("R3 R4 R11 status after commit", status_o, 8'h8F);
    cyc('0);                 chk("R12 grant one cycle", {7'b0, sr_grant}, 8'h00);
    cyc(S_CLR);              chk("R11 clear ignored while busy", status_o, 8'h8F);
    sr_d = 8'h00; cyc(S_SRL);
    cyc(S_CSR);              chk("R11 write ignored while busy", {7'b0, g_sr}, 8'h00);
    cyc(S_WRD);              chk("R2 R11 cycle end", status_o, 8'h8C);

    // R6 pin lock
    wp_n = 1'b0;
    cyc(S_SET);
    sr_d = 8'h00; cyc(S_SRL);
    cyc(S_CSR);              chk("R6 refused grant", {7'b0, g_sr}, 8'h00);
    chk("R6 status unchanged", status_o, 8'h8E);

    // R7 cancellation window
    wp_n = 1'b1;
    sr_d = 8'h00; cyc(S_SRL);
    wp_n = 1'b0; cyc('0);
    wp_n = 1'b1;
    cyc(S_CSR);              chk("R7 cancelled grant", {7'b0, g_sr}, 8'h00);
    chk("R7 status unchanged", status_o, 8'h8E);

    // unlock
    cyc(S_SRL);
    cyc(S_CSR);              chk("R6 pin high grant", {7'b0, g_sr}, 8'h01);
    chk("R3 status cleared", status_o, 8'h03);
    cyc(S_WRD);              chk("R2 after unlock", status_o, 8'h00);

    // R6 pin ignored when enable 0; R9 page offset
    wp_n = 1'b0;
    wr_status(8'h48);        chk("R6 pin ignored", status_o, 8'h48);
    chk("R9 id_sel set", {7'b0, id_sel}, 8'h01);
    wp_n = 1'b1;
    cyc(S_SET);
    addr = 14'h3FC5; cyc(S_ARL);
    cyc(S_CSR);              chk("R9 page offset grant", {7'b0, g_arr}, 8'h01);
    chk("R10 R11 page select cleared", status_o, 8'h0B);
    cyc(S_WRD);

    // R9 full protect refuses page
    wr_status(8'h4C);        chk("R3 page select write", status_o, 8'h4C);
    cyc(S_SET);
    addr = 14'h0005; cyc(S_ARL);
    cyc(S_CSR);              chk("R9 full protect refuses page", {7'b0, g_arr}, 8'h00);
    chk("R10 cleared on refused access", status_o, 8'h0E);

    // R9 lock
    wr_status(8'h10);        chk("R3 lock set", status_o, 8'h10);
    wr_status(8'h40);        chk("R3 lock sticky", status_o, 8'h50);
    cyc(S_SET);
    addr = 14'h0001; cyc(S_ARL);
    cyc(S_CSR);              chk("R9 lock refuses page", {7'b0, g_arr}, 8'h00);
    chk("R10 after lock refusal", status_o, 8'h12);

    // R10 read end
    wr_status(8'h40);        chk("R10 select again", status_o, 8'h50);
    cyc(S_RDD);              chk("R10 read end clears", status_o, 8'h10);

    // R1 persistence over reset
    wr_status(8'h40);
    cyc(S_SET);              chk("R1 before reset", status_o, 8'h52);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;                      chk("R1 after reset", status_o, 8'h10);

    // R4 both bits with lock already set
    wr_status(8'h5C);        chk("R4 both set unchanged", status_o, 8'h1C);
    // R5 status write without latch
    sr_d = 8'h00; cyc(S_SRL);
    cyc(S_CSR);              chk("R5 no latch no grant", {7'b0, g_sr}, 8'h00);
    chk("R5 status kept", status_o, 8'h1C);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule